// File: doc/BRIEF.md
# Delta-Sigma Conversion Sequencer

This block is the digital controller in front of a multiplexed delta-sigma converter. A small write port loads five settings: a control field, an input select, a gain code, a delay-timer count and a word-rate code. A control write can start an offset calibration, one conversion, or an endless run of conversions. Before the first conversion the block waits through a composite settling interval. It then strobes the modulator/filter to convert and collects the done pulses and data words that come back. Each data word is corrected by the stored offset for the effective gain and presented with a one-cycle valid pulse.

The settling interval has four parts: a fixed amplifier settle of 4 ms, the delay-timer count times 4 ms, a 100 µs guard that is always present, and four word periods of the selected rate. All four parts are counted in cycles of a reference clock whose frequency is a parameter. Any rewrite of the input select, gain, delay or rate while the block is active discards the conversion in flight and restarts the interval from zero. In continuous mode the run then goes on without a new start command. A standby input and an active-low power-down input both abort all activity at once.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `start_conv`, `result_valid` and `ctrl_q` are all 0.
- R2: Writing address 0 with bits [1:0] = 01 and bit 2 = 0 runs exactly one conversion. After the done pulse there is one `result_valid` pulse, `ctrl_q` returns to 000 and `busy` falls. No further `start_conv` follows.
- R3: The first `start_conv` after a start command or restart is high after the (N+1)-th rising edge that follows the write edge. N = F·(D+1) + G + 4·P, where F = CLK_HZ/250, G = CLK_HZ/10000, D is the delay register (address 3) and P = CLK_HZ/rate. The rate comes from the code at address 4: 0..7 select 10, 20, 50, 100, 200, 500, 1000, 4000 words/s.
- R4: With D = 0 the interval still contains the guard G (N = F + G + 4·P).
- R5: Mode 10 converts continuously. Each done pulse gives a `result_valid` pulse and a new `start_conv` with no settle, and `ctrl_q` stays 010.
- R6: Writing mode 00 during continuous conversion stops it with no further strobe or result. Writing mode 01 during continuous conversion ends the run and performs one settled single conversion.
- R7: While `stby` is 1 or `pwdn_n` is 0, activity stops at once, `ctrl_q` reads 000, and control writes have no effect (no strobe, `busy` low).
- R8: A write to address 1 (input select), 2 (gain), 3 or 4 while the block is active restarts the interval from zero. It discards any conversion in flight, so no `result_valid` occurs before the new interval ends.
- R9: Writing bit 2 = 1 runs an offset calibration and ignores bits [1:0]. Its data word is stored as the offset of the current effective gain, and it produces no `result_valid`. Bit 2 clears itself and `ctrl_q` reads 000 afterwards.
- R10: `result` equals the data word minus the stored offset of the effective gain, modulo 2^24 (two's complement). Offsets reset to 0.
- R11: Gain code k means gain 2^k (k = 0..7). Input select codes 0..3 are differential inputs and keep the gain code. Code 4 (temperature sensor) and code 5 (supply monitor) force `eff_gain` to 0.
- R12: `busy` is high from the start write to completion for single and calibration runs, and low during continuous conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 input select, 2 gain, 3 delay, 4 rate |
| wr_data | input | 8 | Write data |
| stby | input | 1 | Standby request, high stops conversion |
| pwdn_n | input | 1 | Power-down, low stops conversion |
| conv_done | input | 1 | Conversion-done pulse from modulator/filter |
| conv_data | input | 24 | Raw data word, valid with `conv_done` |
| start_conv | output | 1 | One-cycle start-conversion strobe |
| cal_run | output | 1 | High while a calibration run is active |
| mux_sel | output | 3 | Current input select |
| eff_gain | output | 3 | Effective gain code sent to the amplifier |
| busy | output | 1 | Single or calibration run in progress |
| result_valid | output | 1 | One-cycle pulse with a new result |
| result | output | 24 | Offset-corrected result |
| ctrl_q | output | 3 | Control field readback: bit 2 calibrate, bits 1:0 mode |

## Verification
The hardest case to reach is a rewrite that lands while a conversion is already in flight in continuous mode. The modulator's late done pulse then arrives inside the new settling interval and must vanish. To get there, the bench starts a continuous run and waits for a strobe. It rewrites the input select a few cycles later, while the stub's latency is still counting. It then checks that the next strobe comes exactly one full interval after the rewrite and that no result appears in between. A rewrite partway through a single-shot settle, and stops by mode write, standby and power-down, are reached the same way by timing the stimulus against observed strobes.

// File: rtl/adc_seq_pkg.sv
// Shared constants and types for the conversion sequencer.
// Assumes an 8-bit write port and a 3-bit register address.
package adc_seq_pkg;

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_MUX  = 3'd1;
    localparam logic [2:0] ADR_GAIN = 3'd2;
    localparam logic [2:0] ADR_DLY  = 3'd3;
    localparam logic [2:0] ADR_OWR  = 3'd4;

    localparam int CAL_BIT = 2;
    localparam int WR_MIN  = 10;

    typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_CONV} seq_state_t;
    typedef enum logic [1:0] {OP_SINGLE, OP_CONT, OP_CAL} seq_op_t;

    // Word rate in words per second for each rate code.
    function automatic int word_rate(input int code);
        case (code)
            0:       return 10;
            1:       return 20;
            2:       return 50;
            3:       return 100;
            4:       return 200;
            5:       return 500;
            6:       return 1000;
            default: return 4000;
        endcase
    endfunction

endpackage

// File: rtl/adc_cfg_regs.sv
// Configuration registers: input select, gain, delay count, rate code.
// Flags every configuration write so the sequencer can restart settling,
// and derives the effective gain (internal nodes force gain code 0).
// Assumes input select codes at or above NUM_DIFF are internal nodes.
module adc_cfg_regs
    import adc_seq_pkg::*;
#(
    parameter int MUX_W    = 3,
    parameter int GAIN_W   = 3,
    parameter int DLY_W    = 8,
    parameter int NUM_DIFF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic [MUX_W-1:0]  mux_q,
    output logic [GAIN_W-1:0] gain_q,
    output logic [DLY_W-1:0]  dly_q,
    output logic [2:0]        owr_q,
    output logic [GAIN_W-1:0] eff_gain,
    output logic              cfg_wr
);

    localparam logic [MUX_W-1:0] FIRST_INT = MUX_W'(NUM_DIFF);

    // Decode any write that changes a settling-relevant setting.
    always_comb begin
        cfg_wr = wr_en && (wr_addr == ADR_MUX || wr_addr == ADR_GAIN ||
                           wr_addr == ADR_DLY || wr_addr == ADR_OWR);
    end

    // Register updates from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_q  <= '0;
            gain_q <= '0;
            dly_q  <= '0;
            owr_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_MUX:  mux_q  <= wr_data[MUX_W-1:0];
                ADR_GAIN: gain_q <= wr_data[GAIN_W-1:0];
                ADR_DLY:  dly_q  <= wr_data[DLY_W-1:0];
                ADR_OWR:  owr_q  <= wr_data[2:0];
                default: ;
            endcase
        end
    end

    // Internal measurement nodes bypass the amplifier.
    always_comb begin
        eff_gain = (mux_q >= FIRST_INT) ? '0 : gain_q;
    end

    // Settings only move on a write (R8 relies on this for restarts).
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({mux_q, gain_q, dly_q, owr_q}));

endmodule

// File: rtl/adc_settle_timer.sv
// Composite settling timer. On start it loads F*(D+1) + G + 4*P cycles,
// where F is 4 ms, G is 100 us and P is one word period, all in reference
// clock cycles derived from CLK_HZ. done is high in the last counted cycle.
// Assumes start is a single-cycle pulse; a new start reloads at any time.
module adc_settle_timer
    import adc_seq_pkg::*;
#(
    parameter int CLK_HZ = 100_000,
    parameter int DLY_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DLY_W-1:0] dly,
    input  logic [2:0]       owr,
    output logic             done
);

    localparam int FIX_CYC = CLK_HZ / 250;
    localparam int GRD_CYC = CLK_HZ / 10000;
    localparam int FLT_MAX = 4 * (CLK_HZ / WR_MIN);
    localparam int CNT_W   = $clog2(FIX_CYC * (2 ** DLY_W) + GRD_CYC + FLT_MAX + 1);

    logic [CNT_W-1:0] per_tab [8];
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] cnt;
    logic             run;

    // Word period per rate code, computed from the clock frequency.
    for (genvar i = 0; i < 8; i++) begin : g_per
        assign per_tab[i] = CNT_W'(CLK_HZ / word_rate(i));
    end

    // Total interval length for the current settings.
    always_comb begin
        total = CNT_W'(FIX_CYC) * (CNT_W'(dly) + CNT_W'(1))
              + CNT_W'(GRD_CYC) + (per_tab[owr] << 2);
    end

    // Down counter; run drops after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= total - CNT_W'(1);
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - CNT_W'(1);
        end
    end

    assign done = run && (cnt == '0);

    // The interval ends once per start, never twice in a row.
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/adc_seq_core.sv
// Sequencing core: owns the control field, the run state machine, the
// per-gain offset store and the result register. Starts settling through
// a one-cycle kick (so the timer sees freshly written settings), strobes
// conversions, accepts done pulses only while converting, and self-clears
// control bits on completion. Assumes stop is already combined from
// standby and power-down.
module adc_seq_core
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int GAIN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [2:0]        ctrl_data,
    input  logic              cfg_wr,
    input  logic              stop,
    input  logic [GAIN_W-1:0] eff_gain,
    input  logic              settle_done,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              kick,
    output logic              start_conv,
    output logic              cal_run,
    output logic              busy,
    output logic              result_valid,
    output logic [DATA_W-1:0] result,
    output logic [2:0]        ctrl_q
);

    localparam int NGAIN = 1 << GAIN_W;

    seq_state_t        state;
    seq_op_t           op;
    logic [DATA_W-1:0] offs [NGAIN];

    // Main sequencer: priority stop > control write > restart > progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            op           <= OP_SINGLE;
            ctrl_q       <= '0;
            kick         <= 1'b0;
            start_conv   <= 1'b0;
            result_valid <= 1'b0;
            result       <= '0;
            for (int g = 0; g < NGAIN; g++) offs[g] <= '0;
        end else begin
            kick         <= 1'b0;
            start_conv   <= 1'b0;
            result_valid <= 1'b0;
            if (stop) begin
                state  <= ST_IDLE;
                ctrl_q <= '0;
            end else if (ctrl_wr) begin
                if (ctrl_data[CAL_BIT]) begin
                    ctrl_q <= 3'b100;
                    op     <= OP_CAL;
                    state  <= ST_SETTLE;
                    kick   <= 1'b1;
                end else if (ctrl_data[1:0] == 2'b01) begin
                    ctrl_q <= 3'b001;
                    op     <= OP_SINGLE;
                    state  <= ST_SETTLE;
                    kick   <= 1'b1;
                end else if (ctrl_data[1:0] == 2'b10) begin
                    ctrl_q <= 3'b010;
                    op     <= OP_CONT;
                    state  <= ST_SETTLE;
                    kick   <= 1'b1;
                end else begin
                    ctrl_q <= '0;
                    state  <= ST_IDLE;
                end
            end else if (cfg_wr && state != ST_IDLE) begin
                state <= ST_SETTLE;
                kick  <= 1'b1;
            end else begin
                case (state)
                    ST_SETTLE: begin
                        if (settle_done && !kick) begin
                            state      <= ST_CONV;
                            start_conv <= 1'b1;
                        end
                    end
                    ST_CONV: begin
                        if (conv_done) begin
                            case (op)
                                OP_CAL: begin
                                    offs[eff_gain] <= conv_data;
                                    ctrl_q         <= '0;
                                    state          <= ST_IDLE;
                                end
                                OP_SINGLE: begin
                                    result       <= conv_data - offs[eff_gain];
                                    result_valid <= 1'b1;
                                    ctrl_q       <= '0;
                                    state        <= ST_IDLE;
                                end
                                default: begin
                                    result       <= conv_data - offs[eff_gain];
                                    result_valid <= 1'b1;
                                    start_conv   <= 1'b1;
                                end
                            endcase
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Status flags for the run in progress.
    always_comb begin
        busy    = (state != ST_IDLE) && (op != OP_CONT);
        cal_run = (state != ST_IDLE) && (op == OP_CAL);
    end

    p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (ctrl_q == 3'b000) && !start_conv && !result_valid);

    p_single_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && op == OP_SINGLE && conv_done && !stop && !ctrl_wr && !cfg_wr)
        |=> (ctrl_q == 3'b000) && !busy && result_valid);

    p_cal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && op == OP_CAL && conv_done && !stop && !ctrl_wr && !cfg_wr)
        |=> !result_valid && (ctrl_q == 3'b000));

    p_rv_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(conv_done));

    p_cont_not_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1:0] == 2'b10) |-> !busy);

    p_kick_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !start_conv);

endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the conversion sequencer. Decodes control writes and the stop
// condition, and wires the configuration registers, the settling timer
// and the sequencing core together. Assumes a synchronous active-low reset
// and inputs synchronous to clk.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CLK_HZ   = 100_000,
    parameter int DATA_W   = 24,
    parameter int GAIN_W   = 3,
    parameter int MUX_W    = 3,
    parameter int DLY_W    = 8,
    parameter int NUM_DIFF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              stby,
    input  logic              pwdn_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              start_conv,
    output logic              cal_run,
    output logic [MUX_W-1:0]  mux_sel,
    output logic [GAIN_W-1:0] eff_gain,
    output logic              busy,
    output logic              result_valid,
    output logic [DATA_W-1:0] result,
    output logic [2:0]        ctrl_q
);

    logic              ctrl_wr;
    logic              stop;
    logic              cfg_wr;
    logic              kick;
    logic              settle_done;
    logic [GAIN_W-1:0] gain_q;
    logic [DLY_W-1:0]  dly_q;
    logic [2:0]        owr_q;

    // Control-field write decode and the combined stop condition.
    always_comb begin
        ctrl_wr = wr_en && (wr_addr == ADR_CTRL);
        stop    = stby || !pwdn_n;
    end

    adc_cfg_regs #(
        .MUX_W(MUX_W), .GAIN_W(GAIN_W), .DLY_W(DLY_W), .NUM_DIFF(NUM_DIFF)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mux_q(mux_sel), .gain_q(gain_q), .dly_q(dly_q),
        .owr_q(owr_q), .eff_gain(eff_gain), .cfg_wr(cfg_wr)
    );

    adc_settle_timer #(
        .CLK_HZ(CLK_HZ), .DLY_W(DLY_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .start(kick), .dly(dly_q), .owr(owr_q),
        .done(settle_done)
    );

    adc_seq_core #(
        .DATA_W(DATA_W), .GAIN_W(GAIN_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(wr_data[2:0]),
        .cfg_wr(cfg_wr), .stop(stop), .eff_gain(eff_gain),
        .settle_done(settle_done), .conv_done(conv_done), .conv_data(conv_data),
        .kick(kick), .start_conv(start_conv), .cal_run(cal_run), .busy(busy),
        .result_valid(result_valid), .result(result), .ctrl_q(ctrl_q)
    );

endmodule

// File: tb/adc_mod_stub.sv
// Modulator/filter stand-in: after each start strobe it waits LAT cycles,
// then pulses done for one cycle with the sample value present on din.
// A new start while counting restarts the latency.
module adc_mod_stub #(
    parameter int LAT    = 20,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] din,
    output logic              done,
    output logic [DATA_W-1:0] dout
);

    logic [7:0] cnt;

    // Latency counter and done/data generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
            dout <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                cnt <= 8'(LAT);
            end else if (cnt != '0) begin
                cnt <= cnt - 8'd1;
                if (cnt == 8'd1) begin
                    done <= 1'b1;
                    dout <= din;
                end
            end
        end
    end

endmodule

// File: tb/tb_adc_seq_ctrl.sv
// Directed bench for the conversion sequencer, one task per scenario.
module tb_adc_seq_ctrl;

    localparam int CLK_HZ = 100_000;
    localparam int F      = CLK_HZ / 250;
    localparam int G      = CLK_HZ / 10000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        stby = 1'b0;
    logic        pwdn_n = 1'b1;
    logic [23:0] mod_val = '0;
    logic        conv_done;
    logic [23:0] conv_data;
    logic        start_conv, cal_run, busy, result_valid;
    logic [2:0]  mux_sel, eff_gain, ctrl_q;
    logic [23:0] result;

    int checks = 0;
    int fails  = 0;
    int rv_cnt = 0;
    int st_cnt = 0;

    always #10 clk = ~clk;

    adc_seq_ctrl #(.CLK_HZ(CLK_HZ)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stby(stby), .pwdn_n(pwdn_n),
        .conv_done(conv_done), .conv_data(conv_data),
        .start_conv(start_conv), .cal_run(cal_run), .mux_sel(mux_sel),
        .eff_gain(eff_gain), .busy(busy), .result_valid(result_valid),
        .result(result), .ctrl_q(ctrl_q)
    );

    adc_mod_stub #(.LAT(20), .DATA_W(24)) u_stub (
        .clk(clk), .rst_n(rst_n), .start(start_conv), .din(mod_val),
        .done(conv_done), .dout(conv_data)
    );

    // Pulse counters sampled between edges.
    always @(negedge clk) begin
        if (result_valid) rv_cnt++;
        if (start_conv)   st_cnt++;
    end

    function automatic int settle_n(input int d, input int rate);
        return F * (d + 1) + G + 4 * (CLK_HZ / rate);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(output int c);
        c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (!start_conv && c < 5000);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    endtask

    task automatic wait_rv();
        for (int i = 0; i < 5000 && !result_valid; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 busy", 32'(busy), 0);
        check("R1 start_conv", 32'(start_conv), 0);
        check("R1 result_valid", 32'(result_valid), 0);
        check("R1 ctrl_q", 32'(ctrl_q), 0);
    endtask

    task automatic t_setup();
        wr(3'd1, 8'd0);
        wr(3'd2, 8'd3);
        wr(3'd3, 8'd0);
        wr(3'd4, 8'd7);
        check("R11 eff_gain differential", 32'(eff_gain), 3);
        check("R8 idle write no strobe", 32'(st_cnt), 0);
    endtask

    task automatic t_cal();
        int rv0;
        mod_val = 24'd100;
        rv0 = rv_cnt;
        wr(3'd0, 8'b111);
        check("R12 busy during cal", 32'(busy), 1);
        check("R9 cal_run", 32'(cal_run), 1);
        wait_idle();
        @(negedge clk);
        check("R9 no result from cal", 32'(rv_cnt - rv0), 0);
        check("R9 ctrl self-clear", 32'(ctrl_q), 0);
    endtask

    task automatic t_single();
        int c, st0;
        mod_val = 24'd1100;
        wr(3'd0, 8'b001);
        check("R12 busy during single", 32'(busy), 1);
        measure(c);
        check("R3 R4 settle length d0", 32'(c), 32'(settle_n(0, 4000) + 1));
        wait_rv();
        check("R10 offset corrected", 32'(result), 1000);
        @(negedge clk);
        check("R2 ctrl back to 000", 32'(ctrl_q), 0);
        check("R2 busy low", 32'(busy), 0);
        st0 = st_cnt;
        repeat (100) @(negedge clk);
        check("R2 no second strobe", 32'(st_cnt - st0), 0);
        mod_val = 24'd50;
        wr(3'd0, 8'b001);
        wait_rv();
        check("R10 negative wraps", 32'(result), 32'h00FFFFCE);
        wait_idle();
    endtask

    task automatic t_delay();
        int c;
        wr(3'd3, 8'd1);
        wr(3'd4, 8'd6);
        wr(3'd0, 8'b001);
        measure(c);
        check("R3 settle length d1 rate1000", 32'(c), 32'(settle_n(1, 1000) + 1));
        wait_idle();
        wr(3'd3, 8'd0);
        wr(3'd4, 8'd7);
    endtask

    task automatic t_gain_force();
        wr(3'd1, 8'd4);
        check("R11 temp sensor gain 0", 32'(eff_gain), 0);
        mod_val = 24'd500;
        wr(3'd0, 8'b001);
        wait_rv();
        check("R10 R11 gain0 offset zero", 32'(result), 500);
        wait_idle();
        wr(3'd1, 8'd5);
        check("R11 supply monitor gain 0", 32'(eff_gain), 0);
        wr(3'd1, 8'd2);
        check("R11 differential keeps gain", 32'(eff_gain), 3);
        wr(3'd1, 8'd0);
    endtask

    task automatic t_cont_restart();
        int c, rv0, st0;
        mod_val = 24'd1300;
        wr(3'd0, 8'b010);
        measure(c);
        rv0 = rv_cnt;
        repeat (220) @(negedge clk);
        check("R5 back-to-back results", 32'(rv_cnt - rv0 >= 5), 1);
        check("R5 result value", 32'(result), 1200);
        check("R5 ctrl holds 010", 32'(ctrl_q), 2);
        check("R12 not busy continuous", 32'(busy), 0);
        c = 0;
        while (!start_conv && c < 100) begin @(negedge clk); c++; end
        repeat (3) @(negedge clk);
        rv0 = rv_cnt;
        wr(3'd1, 8'd1);
        measure(c);
        check("R8 restart full interval", 32'(c), 32'(settle_n(0, 4000) + 1));
        check("R8 in-flight result discarded", 32'(rv_cnt - rv0), 0);
        wr(3'd0, 8'b000);
        rv0 = rv_cnt; st0 = st_cnt;
        repeat (600) @(negedge clk);
        check("R6 mode 00 stops results", 32'(rv_cnt - rv0), 0);
        check("R6 mode 00 stops strobes", 32'(st_cnt - st0), 0);
        check("R6 ctrl 000", 32'(ctrl_q), 0);
        wr(3'd0, 8'b010);
        wait_rv();
        @(negedge clk);
        rv0 = rv_cnt;
        wr(3'd0, 8'b001);
        check("R6 switch to single", 32'(ctrl_q), 1);
        wait_idle();
        repeat (50) @(negedge clk);
        check("R6 exactly one result", 32'(rv_cnt - rv0), 1);
        check("R6 ctrl cleared", 32'(ctrl_q), 0);
    endtask

    task automatic t_settle_restart();
        int c;
        wr(3'd0, 8'b001);
        repeat (200) @(negedge clk);
        wr(3'd2, 8'd3);
        measure(c);
        check("R8 gain rewrite mid-settle", 32'(c), 32'(settle_n(0, 4000) + 1));
        wait_idle();
    endtask

    task automatic t_stop_inputs();
        int rv0, st0;
        wr(3'd0, 8'b010);
        while (!start_conv) @(negedge clk);
        stby = 1'b1;
        @(negedge clk);
        check("R7 standby clears ctrl", 32'(ctrl_q), 0);
        rv0 = rv_cnt;
        repeat (600) @(negedge clk);
        check("R7 no results in standby", 32'(rv_cnt - rv0), 0);
        wr(3'd0, 8'b001);
        check("R7 ctrl write ignored", 32'(ctrl_q), 0);
        check("R7 busy low in standby", 32'(busy), 0);
        stby = 1'b0;
        wr(3'd0, 8'b001);
        repeat (50) @(negedge clk);
        pwdn_n = 1'b0;
        @(negedge clk);
        check("R7 power-down busy low", 32'(busy), 0);
        check("R7 power-down ctrl", 32'(ctrl_q), 0);
        st0 = st_cnt;
        repeat (700) @(negedge clk);
        check("R7 no strobe in power-down", 32'(st_cnt - st0), 0);
        pwdn_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup();
        t_cal();
        t_single();
        t_delay();
        t_gain_force();
        t_cont_restart();
        t_settle_restart();
        t_stop_inputs();
        finish_run();
    end

endmodule